// File: doc/BRIEF.md
# Multi-Hart Machine Timer

This block is a memory-mapped machine timer shared by up to eight harts. It holds one free-running 64-bit time counter and one 64-bit compare register per hart. Each hart gets its own level-sensitive timer-pending line, which the hart's core treats as its machine timer interrupt. The core takes that interrupt only when interrupts are globally enabled and the timer enable bit in its interrupt-enable CSR is set, and it reports cause 0x8000_0007 (interrupt flag set, code 7). Those CSRs and trap entry sit in the core, not in this block.

Software reaches the registers through a plain 32-bit read/write port. The map is compact. The counter sits at byte offset 0x00. The compare register for hart N follows at 0x08 + 8×N, so the compare registers form one contiguous array. The block has no software-interrupt region and no other local-interrupt registers. Each 64-bit register appears as two 32-bit words, with the low word at the lower address. Reads are combinational from the current register contents, and writes take effect at the clock edge. A tick-enable input decides in which cycles the counter advances.

Top module: `hart_timer`

## Requirements
- R1: After reset the time counter reads zero, every compare register reads all ones in both words, and no pending line is high.
- R2: In a cycle with tick_en high and no write to the counter, the counter increases by exactly one, carrying from the low word into the high word.
- R3: In a cycle with tick_en low and no write to the counter, the counter keeps its value.
- R4: A write to byte offset 0x00 replaces counter bits 31:0, and a write to 0x04 replaces bits 63:32. The other half keeps its value, and the counter does not increment in that cycle, whatever tick_en is.
- R5: A write to byte offset 0x08 + 8×N (N below NUM_HARTS) replaces bits 31:0 of hart N's compare register, and a write to 0x0C + 8×N replaces bits 63:32. No other register changes.
- R6: Pending line N is high exactly when the counter is greater than or equal to compare register N as unsigned 64-bit numbers. It falls only when the compare value is rewritten above the counter or the counter is rewritten below it.
- R7: A read returns the addressed 32-bit word of the counter or compare register, with the low half at the lower address.
- R8: A read at any byte offset of 0x08 + 8×NUM_HARTS or above returns zero, and a write there changes no register and no pending line.
- R9: The address width is clog2(8×(NUM_HARTS+1)) bits for NUM_HARTS from 1 to 8. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advances by one in each cycle this is high |
| bus_addr | input | ADDR_W | Byte address of the 32-bit word |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tmr_pend | output | NUM_HARTS | Per-hart machine timer pending level |

## Verification
Directed patterns come first. A run of ticks and then idle cycles separates counting from holding. A counter low word loaded with all ones and then ticked shows whether the carry reaches the high word. Writes to the counter with tick_en held high show whether a write correctly takes precedence over the increment. Compare values placed just above the counter, then reached by ticking and then rewritten upward, show the level behaviour and both ways the line can fall. A counter with its top bit set, set against a small compare value, separates an unsigned comparison from a signed one. Writes to the out-of-range region, followed by a full read-back, expose any aliasing onto real registers. Seeded random writes, ticks and reads then mix the halves and harts, and catch decode slips between neighbouring compare slots.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;

  typedef logic [63:0] tval_t;

  // Address width that covers the counter plus one compare slot per hart.
  function automatic int addr_bits(input int harts);
    return $clog2(8 * (harts + 1));
  endfunction

  // Unsigned 64-bit "deadline reached" test.
  function automatic logic deadline_hit(input tval_t now, input tval_t limit);
    return (now >= limit);
  endfunction

  // Replace one 32-bit half of a 64-bit value.
  function automatic tval_t merge_half(input tval_t old, input logic upper,
                                       input logic [31:0] word);
    tval_t r;
    r = old;
    if (upper) r[63:32] = word;
    else       r[31:0]  = word;
    return r;
  endfunction

  // Pick one 32-bit half of a 64-bit value.
  function automatic logic [31:0] pick_half(input tval_t v, input logic upper);
    return upper ? v[63:32] : v[31:0];
  endfunction

endpackage

// File: rtl/hart_timer_decode.sv
module hart_timer_decode
  import hart_timer_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = addr_bits(NUM_HARTS),
  localparam int SLOT_W   = ADDR_W - 3
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  output logic [SLOT_W-1:0]    slot,
  output logic                 upper,
  output logic                 out_of_map,
  output logic                 time_wr_lo,
  output logic                 time_wr_hi,
  output logic [NUM_HARTS-1:0] cmp_wr_lo,
  output logic [NUM_HARTS-1:0] cmp_wr_hi
);

  assign slot       = addr[ADDR_W-1:3];
  assign upper      = addr[2];
  assign out_of_map = (slot > SLOT_W'(NUM_HARTS));

  assign time_wr_lo = we && (slot == '0) && !upper;
  assign time_wr_hi = we && (slot == '0) &&  upper;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_sel
    logic hit;
    assign hit          = (slot == SLOT_W'(h + 1));
    assign cmp_wr_lo[h] = we && hit && !upper;
    assign cmp_wr_hi[h] = we && hit &&  upper;
  end

endmodule

// File: rtl/hart_timer_counter.sv
module hart_timer_counter
  import hart_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output tval_t       time_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= '0;
    end else if (wr_lo || wr_hi) begin
      time_q <= merge_half(time_q, wr_hi, wdata);
    end else if (tick_en) begin
      time_q <= time_q + 64'd1;
    end
  end

endmodule

// File: rtl/hart_timer_cmp_bank.sv
module hart_timer_cmp_bank
  import hart_timer_pkg::*;
#(
  parameter int NUM_HARTS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_HARTS-1:0]    wr_lo,
  input  logic [NUM_HARTS-1:0]    wr_hi,
  input  logic [31:0]             wdata,
  input  tval_t                   time_now,
  output logic [NUM_HARTS*64-1:0] cmp_flat,
  output logic [NUM_HARTS-1:0]    pend
);

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    tval_t cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_q <= '1;
      end else if (wr_lo[h] || wr_hi[h]) begin
        cmp_q <= merge_half(cmp_q, wr_hi[h], wdata);
      end
    end

    assign cmp_flat[h*64 +: 64] = cmp_q;
    assign pend[h]              = deadline_hit(time_now, cmp_q);
  end

endmodule

// File: rtl/hart_timer.sv
module hart_timer
  import hart_timer_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = addr_bits(NUM_HARTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_HARTS-1:0] tmr_pend
);

  localparam int SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0]    slot;
  logic                 upper;
  logic                 out_of_map;
  logic                 time_wr_lo;
  logic                 time_wr_hi;
  logic [NUM_HARTS-1:0] cmp_wr_lo;
  logic [NUM_HARTS-1:0] cmp_wr_hi;
  tval_t                time_q;
  logic [NUM_HARTS*64-1:0] cmp_flat;

  hart_timer_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_dec (
    .addr       (bus_addr),
    .we         (bus_we),
    .slot       (slot),
    .upper      (upper),
    .out_of_map (out_of_map),
    .time_wr_lo (time_wr_lo),
    .time_wr_hi (time_wr_hi),
    .cmp_wr_lo  (cmp_wr_lo),
    .cmp_wr_hi  (cmp_wr_hi)
  );

  hart_timer_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_lo   (time_wr_lo),
    .wr_hi   (time_wr_hi),
    .wdata   (bus_wdata),
    .time_q  (time_q)
  );

  hart_timer_cmp_bank #(.NUM_HARTS(NUM_HARTS)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (cmp_wr_lo),
    .wr_hi    (cmp_wr_hi),
    .wdata    (bus_wdata),
    .time_now (time_q),
    .cmp_flat (cmp_flat),
    .pend     (tmr_pend)
  );

  // Read-back: counter at slot 0, compare array behind it, zero elsewhere.
  always_comb begin
    bus_rdata = '0;
    if (slot == '0) begin
      bus_rdata = pick_half(time_q, upper);
    end else begin
      for (int h = 0; h < NUM_HARTS; h++) begin
        if (slot == SLOT_W'(h + 1)) begin
          bus_rdata = pick_half(cmp_flat[h*64 +: 64], upper);
        end
      end
    end
  end

endmodule

// File: rtl/hart_timer_chk.sv
module hart_timer_chk
  import hart_timer_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int ADDR_W    = addr_bits(NUM_HARTS)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick_en,
  input logic                    bus_we,
  input logic [31:0]             bus_wdata,
  input logic [31:0]             bus_rdata,
  input logic [NUM_HARTS-1:0]    tmr_pend,
  input logic                    time_wr_lo,
  input logic                    time_wr_hi,
  input logic                    out_of_map,
  input tval_t                   time_q,
  input logic [NUM_HARTS*64-1:0] cmp_flat
);

  // R1: registers hold reset values on the first active cycle.
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (time_q == '0 && cmp_flat == '1 && tmr_pend == '0));

  // R2: one tick adds one.
  a_r2_tick_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !time_wr_lo && !time_wr_hi) |=> time_q == $past(time_q) + 64'd1);

  // R3: no tick, no write, no change.
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !time_wr_lo && !time_wr_hi) |=> $stable(time_q));

  // R4: low-half write wins over the increment and keeps the high half.
  a_r4_low_write: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr_lo |=> (time_q[31:0] == $past(bus_wdata) &&
                    time_q[63:32] == $past(time_q[63:32])));

  // R4: high-half write keeps the low half.
  a_r4_high_write: assert property (@(posedge clk) disable iff (!rst_n)
    time_wr_hi |=> (time_q[63:32] == $past(bus_wdata) &&
                    time_q[31:0] == $past(time_q[31:0])));

  // R8: out-of-map reads return zero, writes there leave compares alone.
  a_r8_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_map |-> bus_rdata == '0);

  a_r8_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (out_of_map && bus_we) |=> $stable(cmp_flat));

  // R6: each pending line tracks the unsigned comparison.
  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_pend
    a_r6_pend_level: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_pend[h] == (time_q >= cmp_flat[h*64 +: 64]));
  end

endmodule

bind hart_timer hart_timer_chk #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_en    (tick_en),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .tmr_pend   (tmr_pend),
  .time_wr_lo (time_wr_lo),
  .time_wr_hi (time_wr_hi),
  .out_of_map (out_of_map),
  .time_q     (time_q),
  .cmp_flat   (cmp_flat)
);

// File: tb/tb_hart_timer.sv
module tb_hart_timer;
  localparam int NH = 4;
  localparam int AW = $clog2(8 * (NH + 1));

  logic          clk = 0;
  logic          rst_n = 0;
  logic          tick_en = 0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NH-1:0] tmr_pend;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [63:0] m_time;
  logic [63:0] m_cmp [NH];

  always #4 clk = ~clk;

  hart_timer #(.NUM_HARTS(NH)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_pend(tmr_pend)
  );

  function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
    int s;
    logic [63:0] v;
    s = int'(a >> 3);
    if (s == 0) v = m_time;
    else if (s <= NH) v = m_cmp[s-1];
    else return 32'h0;
    return a[2] ? v[63:32] : v[31:0];
  endfunction

  function automatic logic [NH-1:0] exp_pend();
    logic [NH-1:0] p;
    for (int h = 0; h < NH; h++) p[h] = (m_time >= m_cmp[h]);
    return p;
  endfunction

  task automatic cyc(input logic we, input logic [AW-1:0] a,
                     input logic [31:0] d, input logic tk);
    int s;
    @(negedge clk);
    bus_we = we; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(posedge clk);
    s = int'(a >> 3);
    if (we && s == 0) begin
      if (a[2]) m_time[63:32] = d; else m_time[31:0] = d;
    end else if (tk) begin
      m_time = m_time + 64'd1;
    end
    if (we && s >= 1 && s <= NH) begin
      if (a[2]) m_cmp[s-1][63:32] = d; else m_cmp[s-1][31:0] = d;
    end
  endtask

  task automatic chk_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    bus_we = 0; tick_en = 0; bus_addr = a;
    #1;
    n_chk++;
    if (bus_rdata !== exp_word(a)) begin
      n_bad++;
      $display("FAIL %s read @%0h: got %h exp %h", req, a, bus_rdata, exp_word(a));
    end
  endtask

  task automatic chk_pend(input string req);
    @(negedge clk);
    bus_we = 0; tick_en = 0;
    #1;
    n_chk++;
    if (tmr_pend !== exp_pend()) begin
      n_bad++;
      $display("FAIL %s pend: got %b exp %b", req, tmr_pend, exp_pend());
    end
  endtask

  task automatic chk_all(input string req);
    for (int s = 0; s <= NH; s++) begin
      chk_read(AW'(s * 8), req);
      chk_read(AW'(s * 8 + 4), req);
    end
    chk_pend(req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_time = '0;
    for (int h = 0; h < NH; h++) m_cmp[h] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset values
    chk_all("R1");

    // R2: ticking, R3: holding
    repeat (10) cyc(0, '0, '0, 1);
    chk_read(AW'(0), "R2");
    repeat (5) cyc(0, '0, '0, 0);
    chk_read(AW'(0), "R3");

    // R4: writes override tick, halves independent
    cyc(1, AW'(0), 32'hFFFF_FFFE, 1);
    chk_read(AW'(0), "R4");
    chk_read(AW'(4), "R4");
    cyc(1, AW'(4), 32'h0000_0007, 1);
    chk_read(AW'(4), "R4");
    chk_read(AW'(0), "R4");
    // R2: carry into high word
    repeat (2) cyc(0, '0, '0, 1);
    chk_read(AW'(4), "R2");
    chk_read(AW'(0), "R2");

    // R5, R7: compare halves per hart
    for (int h = 0; h < NH; h++) begin
      cyc(1, AW'(8 + 8 * h), 32'hA000_0000 + h, 0);
      chk_all("R5");
      cyc(1, AW'(12 + 8 * h), 32'h0000_0100 + h, 1);
      chk_all("R7");
    end

    // R6: pending rises on reach, falls on compare rewrite and on counter rewrite
    cyc(1, AW'(4), 32'h0, 0);
    cyc(1, AW'(0), 32'd100, 0);
    for (int h = 0; h < NH; h++) begin
      cyc(1, AW'(12 + 8 * h), 32'h0, 0);
      cyc(1, AW'(8 + 8 * h), 32'd102 + h, 0);
    end
    chk_pend("R6");
    repeat (2) cyc(0, '0, '0, 1);
    chk_pend("R6");
    repeat (2) cyc(0, '0, '0, 1);
    chk_pend("R6");
    cyc(1, AW'(8), 32'd500, 0);
    chk_pend("R6");
    cyc(1, AW'(0), 32'd0, 0);
    chk_pend("R6");
    // R6: unsigned comparison with top bit set
    cyc(1, AW'(4), 32'h8000_0000, 0);
    chk_pend("R6");

    // R8: out-of-map writes ignored, reads zero
    for (int a = 8 * (NH + 1); a < (1 << AW); a += 4) begin
      cyc(1, AW'(a), 32'h0, 0);
      chk_read(AW'(a), "R8");
    end
    chk_all("R8");

    // R9: low address bits ignored on write and read
    cyc(1, AW'(8 + 3), 32'h1234_5678, 0);
    chk_read(AW'(8 + 1), "R9");

    // Random mix
    for (int i = 0; i < 600; i++) begin
      int r;
      logic [AW-1:0] a;
      logic [31:0] d;
      r = int'($urandom % 10);
      a = AW'($urandom) & ~AW'(3);
      d = (r < 3) ? 32'($urandom % 8) : 32'($urandom % 64);
      if (r < 6) cyc(1, a, d, 1'($urandom));
      else repeat (r) cyc(0, '0, '0, 1);
      chk_read(AW'($urandom) & ~AW'(3), "R7");
      chk_pend("R6");
    end

    finish_run();
  end
endmodule